// File: doc/BRIEF.md
# CPU Clock Prescaler Control

This block holds the byte-wide CPU clock divide selection and turns the main system clock into a CPU clock-enable. The enable is a one-cycle pulse in the main clock domain. It repeats every 1, 2, 4, 8 or 16 main cycles, so no derived clock net exists. A source-select input tells the block which oscillator drives the main clock: the ring oscillator (0) or the high-speed oscillator (1). Each source permits a different set of ratios.

Software reaches the register over a simple peripheral bus port. The port takes whole-byte writes, single-bit writes and combinational reads at one fixed byte address. A write whose resulting code is not permitted for the present source is dropped, and an error pulse marks it. A ratio change never cuts a CPU period short: the divider takes up the new ratio only when the current period ends. If the source switches to the ring oscillator while a ratio it cannot support is held, the register drops back to divide-by-2.

Top module: `cpuclk_prescaler`

## Requirements
- R1: After reset the register reads 0x00, `wr_err` is low and `cpu_ce` is high on every cycle (divide by 1).
- R2: Code c in the low three bits makes `cpu_ce` pulse once every 2^c main cycles: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 16.
- R3: Bits 7..3 always read as 0. Writing ones to them changes nothing and raises no error.
- R4: Codes 5, 6 and 7 are refused under both sources. The register keeps its value, and `wr_err` is high for exactly the one cycle after the write edge.
- R5: With `mode_hs` = 0 (ring oscillator), codes 0 and 1 are accepted. Codes 2, 3 and 4 are refused as in R4.
- R6: With `mode_hs` = 1 (high-speed oscillator), codes 0 to 4 are all accepted without an error.
- R7: A single-bit write (`bus_bit_wr` = 1) puts `bus_wdata[0]` into bit `bus_bit_sel` and keeps every other bit. Legality is judged on the merged code.
- R8: Only address 0xFFFB selects the register. A write to any other address has no effect, and a read of any other address returns 0.
- R9: A new ratio takes effect only after the `cpu_ce` pulse that ends the period in progress, so that period keeps its old length.
- R10: If `mode_hs` is 0 while the held code is 2, 3 or 4, the register becomes 1 at the next clock edge with no error. The divider then moves to divide-by-2 at its next period boundary.
- R11: `cpu_ce` is one cycle wide. At any ratio above 1 it is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for the current bus cycle |
| bus_bit_wr | input | 1 | 1 = single-bit write, 0 = whole-byte write |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 8 | Write data; bit 0 is the bit value on a single-bit write |
| bus_bit_sel | input | 3 | Bit index for a single-bit write |
| mode_hs | input | 1 | Main clock source: 0 ring oscillator, 1 high-speed oscillator |
| bus_rdata | output | 8 | Register contents when the address matches, else 0 |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| cpu_ce | output | 1 | CPU clock-enable pulse |

## Verification
Register contents and `wr_err` change at the clock edge that takes the write, and `bus_rdata` follows the register without delay. The bench therefore samples both on the falling edge right after the write cycle. A new ratio shows at `cpu_ce` only after the period in progress ends. So the bench first moves to a pulse, throws away one full interval, and then measures the next interval against 2^code. The period-boundary test instead counts the straddling interval from the pulse before the write, and expects the old length.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

   typedef enum logic {
      SRC_RING = 1'b0,
      SRC_HS   = 1'b1
   } clk_src_e;

   function automatic int unsigned ratio_of(input int unsigned code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/ccp_sel_reg.sv
module ccp_sel_reg
   import ccp_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFFB,
   parameter int unsigned SEL_W         = 3,
   parameter int unsigned MAX_CODE      = 4,
   parameter int unsigned RING_MAX_CODE = 1,
   parameter int unsigned FALLBACK_CODE = 1,
   localparam int unsigned BS_W         = $clog2(DATA_W),
   localparam int unsigned NCODE        = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              bit_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BS_W-1:0]   bit_sel,
   input  logic              mode_hs,
   output logic [SEL_W-1:0]  sel_q,
   output logic              wr_err,
   output logic [DATA_W-1:0] rdata
);

   initial begin
      assert (SEL_W < DATA_W) else $error("select field must fit the data byte");
      assert (MAX_CODE < NCODE) else $error("MAX_CODE exceeds select field");
      assert (RING_MAX_CODE <= MAX_CODE) else $error("ring limit above global limit");
      assert (FALLBACK_CODE <= RING_MAX_CODE) else $error("fallback must be ring-legal");
   end

   clk_src_e           src;
   logic               hit;
   logic [SEL_W-1:0]   cand;
   logic               cand_ok;
   logic [NCODE-1:0]   ok_hs, ok_ring;
   logic               wdata_unused;

   assign src          = clk_src_e'(mode_hs);
   assign hit          = wr_en && (addr == REG_ADDR);
   assign wdata_unused = ^wdata[DATA_W-1:SEL_W];

   // Per-source legality masks over every code the field can hold.
   for (genvar c = 0; c < NCODE; c++) begin : g_mask
      assign ok_hs[c]   = (c <= MAX_CODE);
      assign ok_ring[c] = (c <= RING_MAX_CODE);
   end

   // Candidate code: whole-byte write or one bit merged into the held code.
   always_comb begin
      cand = sel_q;
      if (!bit_wr) begin
         cand = wdata[SEL_W-1:0];
      end else begin
         for (int i = 0; i < SEL_W; i++) begin
            if (bit_sel == BS_W'(i)) cand[i] = wdata[0];
         end
      end
   end

   assign cand_ok = (src == SRC_HS) ? ok_hs[cand] : ok_ring[cand];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         wr_err <= 1'b0;
      end else begin
         wr_err <= hit && !cand_ok;
         if (hit && cand_ok)
            sel_q <= cand;
         else if (src == SRC_RING && !ok_ring[sel_q])
            sel_q <= SEL_W'(FALLBACK_CODE);
      end
   end

   assign rdata = (addr == REG_ADDR) ? {{(DATA_W-SEL_W){1'b0}}, sel_q} : '0;

   p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q <= SEL_W'(MAX_CODE));

   p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(hit));

   p_ring_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_RING) |=> (sel_q <= SEL_W'(RING_MAX_CODE)));

   p_no_stray_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && src == SRC_HS) |=> $stable(sel_q));

endmodule

// File: rtl/ccp_div.sv
module ccp_div
   import ccp_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned MAX_CODE = 4,
   localparam int unsigned CNT_W   = (MAX_CODE < 1) ? 1 : MAX_CODE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             ce_o
);

   initial begin
      assert (MAX_CODE >= 1) else $error("divider needs at least divide-by-2");
      assert (MAX_CODE < 31) else $error("ratio too wide for counter maths");
   end

   logic [SEL_W-1:0] act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   assign lim  = CNT_W'(ratio_of(32'(act_q)) - 32'd1);
   assign ce_o = (cnt_q == lim);

   // The active ratio is reloaded only at a period boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else if (ce_o) begin
         act_q <= sel_i;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim);

   p_hold_ratio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_o |=> $stable(act_q));

   p_no_back2back_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_o && sel_i != '0) |=> !ce_o);

endmodule

// File: rtl/cpuclk_prescaler.sv
module cpuclk_prescaler #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFFB,
   parameter int unsigned SEL_W         = 3,
   parameter int unsigned MAX_CODE      = 4,
   parameter int unsigned RING_MAX_CODE = 1,
   parameter int unsigned FALLBACK_CODE = 1,
   localparam int unsigned BS_W         = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_bit_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [BS_W-1:0]   bus_bit_sel,
   input  logic              mode_hs,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wr_err,
   output logic              cpu_ce
);

   logic [SEL_W-1:0] sel_code;

   ccp_sel_reg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SEL_W(SEL_W),
      .MAX_CODE(MAX_CODE), .RING_MAX_CODE(RING_MAX_CODE),
      .FALLBACK_CODE(FALLBACK_CODE)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .bit_wr(bus_bit_wr),
      .addr(bus_addr), .wdata(bus_wdata), .bit_sel(bus_bit_sel),
      .mode_hs(mode_hs), .sel_q(sel_code), .wr_err(wr_err), .rdata(bus_rdata)
   );

   ccp_div #(
      .SEL_W(SEL_W), .MAX_CODE(MAX_CODE)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_code), .ce_o(cpu_ce)
   );

endmodule

// File: tb/sim_cpuclk_prescaler.sv
module sim_cpuclk_prescaler;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_bit_wr = 1'b0, mode_hs = 1'b0;
   logic [15:0] bus_addr = 16'hFFFB;
   logic [7:0]  bus_wdata = '0;
   logic [2:0]  bus_bit_sel = '0;
   logic [7:0]  bus_rdata;
   logic        wr_err, cpu_ce;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cpuclk_prescaler u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_bit_wr(bus_bit_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_bit_sel(bus_bit_sel),
      .mode_hs(mode_hs), .bus_rdata(bus_rdata), .wr_err(wr_err), .cpu_ce(cpu_ce)
   );

   // Fields: mode, bit_wr, bit_sel[2:0], wdata[7:0], exp_err, exp_code[2:0]
   localparam int NV = 15;
   localparam logic [16:0] VEC [0:NV-1] = '{
      {1'b1, 1'b0, 3'd0, 8'h04, 1'b0, 3'd4},
      {1'b1, 1'b0, 3'd0, 8'h03, 1'b0, 3'd3},
      {1'b1, 1'b0, 3'd0, 8'h05, 1'b1, 3'd3},
      {1'b1, 1'b0, 3'd0, 8'h07, 1'b1, 3'd3},
      {1'b1, 1'b0, 3'd0, 8'hFA, 1'b0, 3'd2},
      {1'b1, 1'b1, 3'd0, 8'h01, 1'b0, 3'd3},
      {1'b1, 1'b1, 3'd2, 8'h01, 1'b1, 3'd3},
      {1'b1, 1'b1, 3'd6, 8'h01, 1'b0, 3'd3},
      {1'b1, 1'b0, 3'd0, 8'h01, 1'b0, 3'd1},
      {1'b0, 1'b0, 3'd0, 8'h02, 1'b1, 3'd1},
      {1'b0, 1'b0, 3'd0, 8'h04, 1'b1, 3'd1},
      {1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0},
      {1'b0, 1'b1, 3'd0, 8'h01, 1'b0, 3'd1},
      {1'b0, 1'b1, 3'd1, 8'h01, 1'b1, 3'd1},
      {1'b0, 1'b0, 3'd0, 8'h06, 1'b1, 3'd1}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic m, input logic bw, input logic [2:0] bs,
                           input logic [7:0] d, output logic e, output logic [7:0] rd);
      mode_hs = m; bus_bit_wr = bw; bus_bit_sel = bs; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      e = wr_err; rd = bus_rdata;
      bus_wr_en = 1'b0; bus_bit_wr = 1'b0;
   endtask

   task automatic sync_ce();
      do @(negedge clk); while (!cpu_ce);
   endtask

   task automatic gap(output int g);
      g = 0;
      do begin @(negedge clk); g++; end while (!cpu_ce);
   endtask

   task automatic settled_gap(output int g);
      int skip;
      sync_ce();
      gap(skip);
      gap(g);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic e;
      logic [7:0] rd;
      int g, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", bus_rdata, 0);
      check("R1 wr_err", wr_err, 0);
      check("R1 ce", cpu_ce, 1);
      gap(g);
      check("R1 gap", g, 1);

      // Table walk: R2..R7, R11
      for (int i = 0; i < NV; i++) begin
         logic [16:0] v;
         v = VEC[i];
         do_write(v[16], v[15], v[14:12], v[11:4], e, rd);
         check($sformatf("R4/R5/R6/R7 err vec%0d", i), e, v[3]);
         check($sformatf("R3/R7 rdata vec%0d", i), rd, {5'b0, v[2:0]});
         settled_gap(g);
         check($sformatf("R2/R11 gap vec%0d", i), g, 1 << v[2:0]);
      end

      // R8 address decode
      mode_hs = 1'b1;
      bus_addr = 16'hFFFA;
      do_write(1'b1, 1'b0, 3'd0, 8'h04, e, rd);
      check("R8 err other addr", e, 0);
      check("R8 read other addr", rd, 0);
      bus_addr = 16'hFFFB;
      #1;
      check("R8 register unchanged", bus_rdata, 1);

      // R9 change lands at period boundary
      do_write(1'b1, 1'b0, 3'd0, 8'h04, e, rd);
      settled_gap(g);
      check("R9 setup gap", g, 16);
      c = 0;
      repeat (3) begin @(negedge clk); c++; end
      do_write(1'b1, 1'b0, 3'd0, 8'h00, e, rd);
      c++;
      check("R9 write accepted", rd, 0);
      while (!cpu_ce) begin @(negedge clk); c++; end
      check("R9 straddling period", c, 16);
      gap(g);
      check("R9 new ratio", g, 1);

      // R10 fallback on switch to ring oscillator
      do_write(1'b1, 1'b0, 3'd0, 8'h04, e, rd);
      settled_gap(g);
      check("R10 setup gap", g, 16);
      mode_hs = 1'b0;
      @(negedge clk);
      check("R10 register fallback", bus_rdata, 1);
      check("R10 no error", wr_err, 0);
      settled_gap(g);
      check("R10/R11 divide-by-2", g, 2);

      finish_run();
   end

endmodule